// File: doc/BRIEF.md
# PRBS23 Bit-Error Checker with Lock-Gated Reset

This block checks a serial NRZ stream that should follow the maximal-length sequence of x^23 + x^18 + 1, which has a period of 2^23-1. It takes one bit on every edge of the recovered clock. A source selector feeds that bit from one of two places: one chosen core output channel, or a dedicated external input. The checker locks onto the incoming sequence by itself. It counts each mismatched bit in a saturating error counter and raises a sync flag once the stream has been clean for long enough.

Software enables the checker through a register bit, or a board pin pulls an active-low enable pin. Either one is enough. The checker is held in reset by any of three things: a register bit, an active-low reset pin, or a nonzero value on either of the two clock-recovery alarm bits. Because of the alarm path, the count only starts once recovery has settled. A clear strobe zeroes the count when software reads it.

The control flow is one state machine with four states:
- `ST_IDLE`: disabled or held.
- `ST_LOAD`: filling the shift register from the stream.
- `ST_HUNT`: comparing, but not yet in sync.
- `ST_LOCK`: in sync.

The transitions are named as follows:
- T_START: `ST_IDLE` to `ST_LOAD`, once the checker is active.
- T_FILLED: `ST_LOAD` to `ST_HUNT`, after 23 bits have been loaded.
- T_ACQUIRE: `ST_HUNT` to `ST_LOCK`, after 64 clean comparisons in a row.
- T_SLIP: `ST_HUNT` or `ST_LOCK` to `ST_LOAD`, after 8 errors within one 64-comparison window.
- T_HALT: any state to `ST_IDLE`, whenever the checker is held or disabled.

Top module: `prbs23_err_chk`

## Requirements
- R1: After `rst_n` is released, `err_cnt` is 0 and `sync_ok` is 0.
- R2: In `ST_HUNT` or `ST_LOCK`, a received bit is an error when it differs from the XOR of the bits received 18 and 23 bits earlier. A clean sequence therefore adds no errors.
- R3: The checker is enabled when `cfg_chk_en`=1 or `pin_en_n`=0. While disabled and not held, `sync_ok` is 0 and `err_cnt` keeps its value.
- R4: When `cfg_src_ext`=1, `ext_bit` is checked. When it is 0, `core_bits[cfg_core_sel]` is checked.
- R5: When `cfg_src_ext`=0 and either `cfg_core_link`=0 or `cfg_core_sel` >= NUM_CH, a constant 0 is checked.
- R6: While `cfg_hold_rst`=1, `pin_rst_n`=0 or `cdr_alarm` is nonzero, the next edge clears `err_cnt` to 0 and `sync_ok` to 0.
- R7: The first 23 bits after leaving reset, and the 23 bits after each T_SLIP, are only loaded. They never count as errors.
- R8: One flipped bit in a locked clean stream adds exactly 3 errors: at the flipped bit, 18 bits later and 23 bits later.
- R9: `sync_ok` rises on the edge of the 64th consecutive error-free comparison.
- R10: The 8th error within a 64-comparison window clears `sync_ok` and causes a 23-bit reload. Each window restarts at T_FILLED and at T_ACQUIRE.
- R11: Every comparison made while the shift register holds all zeros counts as an error. An all-zero stream therefore adds 8 errors for every 31 bits.
- R12: `err_cnt` saturates at 2^ERR_W-1.
- R13: `err_clr`=1 zeroes `err_cnt` on the next edge, even if an error occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| cfg_chk_en | input | 1 | Register enable |
| pin_en_n | input | 1 | Pin enable, active low |
| cfg_src_ext | input | 1 | 1 = external input, 0 = core channel |
| cfg_core_link | input | 1 | 1 allows a core channel to feed the checker |
| cfg_core_sel | input | SEL_W | Core channel index |
| core_bits | input | NUM_CH | Core output bits |
| ext_bit | input | 1 | External input bit |
| cfg_hold_rst | input | 1 | Register reset hold |
| pin_rst_n | input | 1 | Pin reset hold, active low |
| cdr_alarm | input | 2 | Clock-recovery alarms; nonzero holds the checker |
| err_clr | input | 1 | Clear-on-read strobe |
| err_cnt | output | ERR_W | Saturating error count |
| sync_ok | output | 1 | Checker is in `ST_LOCK` |

## Verification
The checker is first fed a clean sequence. This shows the tap choice and the load length, because with wrong taps the count would not stay at zero and `sync_ok` would rise at the wrong bit. Next, a single flipped bit shows that the received bit itself is shifted in: exactly three errors appear. A burst of inverted bits separates the seventh error from the eighth at the loss threshold. Finally, an all-zero stream, produced by an unlinked or out-of-range core channel, shows that the zero state is rejected. Its 31-bit period of eight errors also drives the counter to saturation and tests clear-over-increment.

// File: rtl/prbs23_pkg.sv
package prbs23_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_HUNT,
        ST_LOCK
    } chk_state_e;

    localparam int PRBS_LEN = 23;
    localparam int TAP_FAR  = 23;
    localparam int TAP_NEAR = 18;

endpackage

// File: rtl/prbs23_src_sel.sv
module prbs23_src_sel #(
    parameter int NUM_CH = 72,
    parameter int SEL_W  = 8
) (
    input  logic              src_ext,
    input  logic              core_link,
    input  logic [SEL_W-1:0]  core_sel,
    input  logic [NUM_CH-1:0] core_bits,
    input  logic              ext_bit,
    output logic              rx_bit
);

    logic core_bit;

    // Level 1: pick one core channel (constant 0 when unlinked or out of range)
    always_comb begin
        core_bit = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (core_link && (int'(core_sel) == i)) begin
                core_bit = core_bits[i];
            end
        end
    end

    // Level 2: core path or external path
    assign rx_bit = src_ext ? ext_bit : core_bit;

endmodule

// File: rtl/prbs23_sync_fsm.sv
module prbs23_sync_fsm
    import prbs23_pkg::*;
#(
    parameter int RUN_LEN   = 64,
    parameter int WIN_LEN   = 64,
    parameter int LOSS_ERRS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic rx_bit,
    output logic bit_err,
    output logic in_lock
);

    localparam int RUN_W = $clog2(RUN_LEN + 1);
    localparam int WIN_W = $clog2(WIN_LEN);
    localparam int ECW   = $clog2(LOSS_ERRS + 1);
    localparam int LD_W  = $clog2(PRBS_LEN);

    chk_state_e            state_q, state_d;
    logic [PRBS_LEN-1:0]   sr_q;
    logic [LD_W-1:0]       ld_q;
    logic [RUN_W-1:0]      run_q, run_nx;
    logic [WIN_W-1:0]      win_q;
    logic [ECW-1:0]        werr_q, werr_nx;
    logic                  pred, mism, comparing, slip, acquire;

    // Prediction from the two taps; an all-zero register is never accepted
    assign pred      = sr_q[TAP_FAR-1] ^ sr_q[TAP_NEAR-1];
    assign mism      = (rx_bit != pred) || (sr_q == '0);
    assign comparing = active && ((state_q == ST_HUNT) || (state_q == ST_LOCK));
    assign werr_nx   = werr_q + ECW'(comparing && mism);
    assign slip      = comparing && (werr_nx >= ECW'(LOSS_ERRS));
    assign run_nx    = mism ? '0 : run_q + RUN_W'(1);
    assign acquire   = (state_q == ST_HUNT) && !slip && (run_nx == RUN_W'(RUN_LEN));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (active) state_d = ST_LOAD;                          // T_START
            ST_LOAD: begin
                if (!active)                           state_d = ST_IDLE;   // T_HALT
                else if (ld_q == LD_W'(PRBS_LEN - 1))  state_d = ST_HUNT;   // T_FILLED
            end
            ST_HUNT: begin
                if (!active)      state_d = ST_IDLE;                         // T_HALT
                else if (slip)    state_d = ST_LOAD;                         // T_SLIP
                else if (acquire) state_d = ST_LOCK;                         // T_ACQUIRE
            end
            ST_LOCK: begin
                if (!active)   state_d = ST_IDLE;                            // T_HALT
                else if (slip) state_d = ST_LOAD;                            // T_SLIP
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '0;
            ld_q   <= '0;
            run_q  <= '0;
            win_q  <= '0;
            werr_q <= '0;
        end else if (!active) begin
            ld_q   <= '0;
            run_q  <= '0;
            win_q  <= '0;
            werr_q <= '0;
        end else begin
            sr_q <= {sr_q[PRBS_LEN-2:0], rx_bit};
            unique case (state_q)
                ST_IDLE: begin
                    ld_q   <= LD_W'(1);
                    run_q  <= '0;
                    win_q  <= '0;
                    werr_q <= '0;
                end
                ST_LOAD: begin
                    ld_q   <= ld_q + LD_W'(1);
                    run_q  <= '0;
                    win_q  <= '0;
                    werr_q <= '0;
                end
                ST_HUNT, ST_LOCK: begin
                    ld_q  <= '0;
                    run_q <= (state_q == ST_HUNT) ? run_nx : '0;
                    if (slip || acquire || (win_q == WIN_W'(WIN_LEN - 1))) begin
                        win_q  <= '0;
                        werr_q <= '0;
                    end else begin
                        win_q  <= win_q + WIN_W'(1);
                        werr_q <= werr_nx;
                    end
                end
                default: ld_q <= '0;
            endcase
        end
    end

    // Outputs
    always_comb begin
        bit_err = comparing && mism;
        in_lock = (state_q == ST_LOCK);
    end

endmodule

// File: rtl/prbs23_err_cnt.sv
module prbs23_err_cnt #(
    parameter int ERR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             clr,
    input  logic             inc,
    output logic [ERR_W-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  count <= '0;
        else if (hold || clr)        count <= '0;
        else if (inc && !(&count))   count <= count + ERR_W'(1);
    end

endmodule

// File: rtl/prbs23_err_chk.sv
module prbs23_err_chk #(
    parameter int NUM_CH = 72,
    parameter int SEL_W  = 8,
    parameter int ERR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_chk_en,
    input  logic              pin_en_n,
    input  logic              cfg_src_ext,
    input  logic              cfg_core_link,
    input  logic [SEL_W-1:0]  cfg_core_sel,
    input  logic [NUM_CH-1:0] core_bits,
    input  logic              ext_bit,
    input  logic              cfg_hold_rst,
    input  logic              pin_rst_n,
    input  logic [1:0]        cdr_alarm,
    input  logic              err_clr,
    output logic [ERR_W-1:0]  err_cnt,
    output logic              sync_ok
);

    logic rx_bit, held, enabled, active, bit_err;

    assign held    = cfg_hold_rst || !pin_rst_n || (cdr_alarm != 2'b00);
    assign enabled = cfg_chk_en || !pin_en_n;
    assign active  = enabled && !held;

    prbs23_src_sel #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) src_i (
        .src_ext   (cfg_src_ext),
        .core_link (cfg_core_link),
        .core_sel  (cfg_core_sel),
        .core_bits (core_bits),
        .ext_bit   (ext_bit),
        .rx_bit    (rx_bit)
    );

    prbs23_sync_fsm fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .rx_bit  (rx_bit),
        .bit_err (bit_err),
        .in_lock (sync_ok)
    );

    prbs23_err_cnt #(.ERR_W(ERR_W)) cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (held),
        .clr   (err_clr),
        .inc   (bit_err),
        .count (err_cnt)
    );

endmodule

// File: rtl/prbs23_err_chk_sva.sv
module prbs23_err_chk_sva #(
    parameter int ERR_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_chk_en,
    input logic             pin_en_n,
    input logic             cfg_hold_rst,
    input logic             pin_rst_n,
    input logic [1:0]       cdr_alarm,
    input logic             err_clr,
    input logic [ERR_W-1:0] err_cnt,
    input logic             sync_ok
);

    logic hold_in, en_in;
    assign hold_in = cfg_hold_rst || !pin_rst_n || (cdr_alarm != 2'b00);
    assign en_in   = cfg_chk_en || !pin_en_n;

    // R6
    hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_in |=> (err_cnt == '0) && !sync_ok);

    // R13
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> (err_cnt == '0));

    // R12
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((&err_cnt) && !err_clr && !hold_in) |=> (&err_cnt));

    // R3
    idle_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_in && !hold_in && !err_clr) |=> ($stable(err_cnt) && !sync_ok));

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_in && !err_clr && !(&err_cnt)) |=>
            ((err_cnt == $past(err_cnt)) || (err_cnt == $past(err_cnt) + ERR_W'(1))));

    // R9
    sync_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sync_ok) && !$past(err_clr)) |-> (err_cnt == $past(err_cnt)));

endmodule

bind prbs23_err_chk prbs23_err_chk_sva #(.ERR_W(ERR_W)) sva_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_chk_en   (cfg_chk_en),
    .pin_en_n     (pin_en_n),
    .cfg_hold_rst (cfg_hold_rst),
    .pin_rst_n    (pin_rst_n),
    .cdr_alarm    (cdr_alarm),
    .err_clr      (err_clr),
    .err_cnt      (err_cnt),
    .sync_ok      (sync_ok)
);

// File: tb/prbs23_err_chk_tb_top.sv
module prbs23_err_chk_tb_top;

    localparam int NUM_CH = 72;
    localparam int SEL_W  = 8;
    localparam int ERR_W  = 5;

    typedef struct {
        string tag;
        int    cnt;
        bit    sync;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_chk_en = 1'b0;
    logic              pin_en_n = 1'b1;
    logic              cfg_src_ext = 1'b1;
    logic              cfg_core_link = 1'b1;
    logic [SEL_W-1:0]  cfg_core_sel = '0;
    logic [NUM_CH-1:0] core_bits = '0;
    logic              ext_bit = 1'b0;
    logic              cfg_hold_rst = 1'b0;
    logic              pin_rst_n = 1'b1;
    logic [1:0]        cdr_alarm = 2'b00;
    logic              err_clr = 1'b0;
    logic [ERR_W-1:0]  err_cnt;
    logic              sync_ok;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 1'b0;
    exp_t sb_q[$];
    logic [22:0] gen_q = 23'h1ACE5;
    bit   use_core = 1'b0;

    always #10 clk = ~clk;

    prbs23_err_chk #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .ERR_W(ERR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_chk_en(cfg_chk_en), .pin_en_n(pin_en_n),
        .cfg_src_ext(cfg_src_ext), .cfg_core_link(cfg_core_link),
        .cfg_core_sel(cfg_core_sel), .core_bits(core_bits), .ext_bit(ext_bit),
        .cfg_hold_rst(cfg_hold_rst), .pin_rst_n(pin_rst_n), .cdr_alarm(cdr_alarm),
        .err_clr(err_clr), .err_cnt(err_cnt), .sync_ok(sync_ok)
    );

    // Driver: present one bit, let one edge consume it, step off the edge
    task automatic drive_bit(input bit b);
        if (use_core) begin
            core_bits = {NUM_CH{~b}};
            core_bits[5] = b;
            ext_bit = 1'b0;
        end else begin
            core_bits = {NUM_CH{b}};
            ext_bit = b;
        end
        @(posedge clk);
        #1;
    endtask

    // Next bit of x^23 + x^18 + 1, optionally inverted
    task automatic send_prbs(input int n, input bit invert);
        for (int i = 0; i < n; i++) begin
            bit nb;
            nb = gen_q[22] ^ gen_q[17];
            gen_q = {gen_q[21:0], nb};
            drive_bit(nb ^ invert);
        end
    endtask

    task automatic send_const(input int n, input bit b);
        for (int i = 0; i < n; i++) drive_bit(b);
    endtask

    task automatic expect_out(input string tag, input int cnt, input bit sync);
        exp_t e;
        e.tag = tag;
        e.cnt = cnt;
        e.sync = sync;
        sb_q.push_back(e);
    endtask

    // Monitor: compare away from the active edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if ((int'(err_cnt) != e.cnt) || (sync_ok != e.sync)) begin
                n_errors++;
                $display("FAIL %s: err_cnt=%0d sync_ok=%0d expected err_cnt=%0d sync_ok=%0d",
                         e.tag, err_cnt, sync_ok, e.cnt, e.sync);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        expect_out("R1 reset state", 0, 0);

        // R3: disabled, garbage ignored
        send_const(40, 1'b1);
        expect_out("R3 disabled", 0, 0);

        // R7 / R9 / R2: register enable, external source, clean stream
        cfg_chk_en = 1'b1;
        send_prbs(23, 0);
        expect_out("R7 load only", 0, 0);
        send_prbs(63, 0);
        expect_out("R9 63 clean", 0, 0);
        send_prbs(1, 0);
        expect_out("R9 64th clean", 0, 1);
        send_prbs(20, 0);
        expect_out("R2 clean stays zero", 0, 1);

        // R8: one flipped bit
        send_prbs(1, 1);
        send_prbs(30, 0);
        expect_out("R8 single flip", 3, 1);

        // R6: register hold
        cfg_hold_rst = 1'b1;
        send_prbs(1, 0);
        expect_out("R6 register hold", 0, 0);
        cfg_hold_rst = 1'b0;

        // R10: resync, then an inverted burst
        send_prbs(87, 0);
        expect_out("R4 external resync", 0, 1);
        send_prbs(7, 1);
        expect_out("R10 seven errors", 7, 1);
        send_prbs(1, 1);
        expect_out("R10 eighth error", 8, 0);

        // R6: alarm hold
        cdr_alarm = 2'b10;
        send_prbs(5, 0);
        expect_out("R6 alarm hold", 0, 0);
        cdr_alarm = 2'b00;

        // R4 / R3: pin enable, core channel 5
        cfg_chk_en = 1'b0;
        pin_en_n = 1'b0;
        cfg_src_ext = 1'b0;
        cfg_core_sel = 8'd5;
        use_core = 1'b1;
        send_prbs(87, 0);
        expect_out("R4 core channel 5", 0, 1);

        // R6: pin hold
        pin_rst_n = 1'b0;
        send_prbs(2, 0);
        expect_out("R6 pin hold", 0, 0);
        pin_rst_n = 1'b1;

        // R5 / R11: out-of-range channel feeds zeros
        cfg_core_sel = 8'd200;
        use_core = 1'b0;
        send_prbs(31, 0);
        expect_out("R5 out-of-range select", 8, 0);
        send_prbs(23, 0);
        expect_out("R7 reload after slip", 8, 0);
        send_prbs(5, 0);
        expect_out("R11 zero register errors", 13, 0);

        // R13: clear wins over a same-cycle error
        err_clr = 1'b1;
        send_prbs(1, 0);
        expect_out("R13 clear wins", 0, 0);
        err_clr = 1'b0;
        send_prbs(1, 0);
        expect_out("R13 count resumes", 1, 0);

        // R12: saturation
        send_prbs(1, 0);
        send_prbs(124, 0);
        expect_out("R12 saturate", 31, 0);
        send_prbs(31, 0);
        expect_out("R12 stays saturated", 31, 0);

        // R5: core link off with stream on channel 5
        pin_rst_n = 1'b0;
        send_prbs(1, 0);
        pin_rst_n = 1'b1;
        cfg_core_sel = 8'd5;
        cfg_core_link = 1'b0;
        use_core = 1'b1;
        send_prbs(31, 0);
        expect_out("R5 core link off", 8, 0);

        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule